// File: doc/BRIEF.md
# Receive Descriptor Ring Writeback Engine

This block takes received frames from a byte stream and places each one into a memory buffer that software has set up in a ring of 16-byte receive descriptors. A descriptor has four words:

- status at offset 0
- a tag word at offset 4
- the low buffer address at offset 8
- the high buffer address at offset 12

Software hands a descriptor to the engine by setting bit 31 (ownership) and putting the buffer size in bits 12:0. Bit 30 marks the last descriptor of the ring.

When a frame begins, the engine reads the current descriptor's status word and its low buffer address. It packs the incoming bytes into 32-bit words and stores them in the buffer. When the frame ends, it writes the status word back with ownership cleared, the byte count (CRC bytes included) and the error classes. It then moves on to the next descriptor, or back to descriptor 0 after the one marked as last.

A frame that finds its descriptor still owned by software is dropped. The drop is counted in a missed-frame counter and flagged in the interrupt status.

The register port is a single-cycle write with a combinational read. The memory port is word wide: a write takes effect at the clock edge, and read data is returned on the cycle after the request. The byte stream has no back-pressure. The source leaves at least two idle cycles after the last byte of a frame.

Top module: `rxdesc_wb`

## Requirements
- R1: After reset every register reads zero and no memory request is made. Register offsets: ring base 0x00, control 0x04, maximum length 0x08, missed counter 0x0C, interrupt status 0x10.
- R2: A frame whose first byte arrives while control bit 3 is clear is discarded. It causes no memory request and no change to the counter or the interrupt status.
- R3: With control bit 3 set, the frame's bytes are stored from the buffer address in little-endian order (byte n of a word in bits 8n+7:8n), and a partial last word is zero padded. The status written back has bit 31 clear, bit 30 kept from the fetched status, and the total byte count in bits 12:0.
- R4: The storage limit is the smaller of the descriptor's buffer size (status bits 12:0) and the maximum length register (bits 12:0). Bytes past the limit are not stored. The written length equals the limit, and bits 22 and 21 are set.
- R5: A frame of fewer than 64 bytes sets bits 20 and 21 in the written status.
- R6: An error flag on any byte of the frame sets bits 19 and 21 in the written status.
- R7: After a writeback, the next frame uses the following descriptor (ring base plus 16 per index). After the descriptor with bit 30 set, it uses descriptor 0.
- R8: If the fetched status has bit 31 clear, the frame is dropped without any memory write. The missed counter increments, saturating at its maximum. Interrupt status bit 4 is set. The descriptor index does not change.
- R9: A writeback with bit 21 clear sets interrupt status bit 0; one with bit 21 set sets bit 1. Writing 1 to an interrupt status bit clears it, but a set in the same cycle wins.
- R10: Writing the missed counter clears it. If a drop falls in the same cycle as the clear, the counter reads 1.
- R11: The ring base register keeps bits 7:0 at zero, whatever value is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, the cycle after a read request |
| rx_valid | input | 1 | Stream byte valid |
| rx_data | input | 8 | Stream byte |
| rx_last | input | 1 | Byte is the last of the frame |
| rx_err | input | 1 | Frame error flag (CRC failure seen upstream) |

## Verification
A dropped frame increments the missed counter and sets interrupt status bit 4. Software can clear either register in that same cycle, so two cases fall together:

- a clear of the missed counter and a drop;
- a write-1-to-clear of bit 4 and a fresh drop.

The bench provokes each case by issuing the register write alongside the third byte of a frame aimed at a descriptor software still owns. That third byte arrives in the very cycle the ownership decision is taken. The case is judged by reading back a counter of 1 and a bit 4 that is still set.

// File: rtl/rxdesc_wb_pkg.sv
package rxdesc_wb_pkg;

  localparam int LEN_W    = 13;
  localparam int OWN_BIT  = 31;
  localparam int EOR_BIT  = 30;
  localparam int WD_BIT   = 22;
  localparam int SUM_BIT  = 21;
  localparam int RUNT_BIT = 20;
  localparam int CRC_BIT  = 19;
  localparam int EN_BIT   = 3;
  localparam int ISR_OK   = 0;
  localparam int ISR_ERR  = 1;
  localparam int ISR_NOBUF = 4;

  localparam logic [7:0] OFS_BASE   = 8'h00;
  localparam logic [7:0] OFS_CTRL   = 8'h04;
  localparam logic [7:0] OFS_MAXLEN = 8'h08;
  localparam logic [7:0] OFS_MISSED = 8'h0C;
  localparam logic [7:0] OFS_ISR    = 8'h10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_STAT, ST_ADDR, ST_RECV, ST_FLUSH, ST_WBACK, ST_SKIP
  } rx_state_t;

  function automatic logic [LEN_W-1:0] len_min(input logic [LEN_W-1:0] a,
                                               input logic [LEN_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [31:0] wb_status(input logic eor, input logic crc,
                                            input logic runt, input logic wd,
                                            input logic [LEN_W-1:0] len);
    logic [31:0] s;
    s = '0;
    s[EOR_BIT]  = eor;
    s[WD_BIT]   = wd;
    s[RUNT_BIT] = runt;
    s[CRC_BIT]  = crc;
    s[SUM_BIT]  = crc | runt | wd;
    s[LEN_W-1:0] = len;
    return s;
  endfunction

endpackage

// File: rtl/rxdesc_wb_regs.sv
module rxdesc_wb_regs
  import rxdesc_wb_pkg::*;
#(
  parameter int MISS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             drop_evt,
  input  logic             ok_evt,
  input  logic             err_evt,
  output logic [31:0]      ring_base,
  output logic             rx_en,
  output logic [LEN_W-1:0] max_len
);

  logic [31:0]       base_q;
  logic              en_q;
  logic [LEN_W-1:0]  maxlen_q;
  logic [MISS_W-1:0] missed_q, missed_n;
  logic [4:0]        isr_q, isr_n;
  logic              wr_miss, wr_isr;

  assign wr_miss = reg_wr && (reg_addr == OFS_MISSED);
  assign wr_isr  = reg_wr && (reg_addr == OFS_ISR);

  // Clear first, then count: a drop in the clearing cycle leaves 1.
  always_comb begin
    missed_n = missed_q;
    if (wr_miss) missed_n = '0;
    if (drop_evt && (missed_n != '1)) missed_n = missed_n + 1'b1;
    isr_n = isr_q;
    if (wr_isr) isr_n = isr_q & ~reg_wdata[4:0];
    if (ok_evt)   isr_n[ISR_OK]    = 1'b1;
    if (err_evt)  isr_n[ISR_ERR]   = 1'b1;
    if (drop_evt) isr_n[ISR_NOBUF] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      en_q     <= 1'b0;
      maxlen_q <= '0;
      missed_q <= '0;
      isr_q    <= '0;
    end else begin
      if (reg_wr && reg_addr == OFS_BASE)   base_q   <= {reg_wdata[31:8], 8'h00};
      if (reg_wr && reg_addr == OFS_CTRL)   en_q     <= reg_wdata[EN_BIT];
      if (reg_wr && reg_addr == OFS_MAXLEN) maxlen_q <= reg_wdata[LEN_W-1:0];
      missed_q <= missed_n;
      isr_q    <= isr_n;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_BASE:   reg_rdata = base_q;
      OFS_CTRL:   reg_rdata = 32'(en_q) << EN_BIT;
      OFS_MAXLEN: reg_rdata = 32'(maxlen_q);
      OFS_MISSED: reg_rdata = 32'(missed_q);
      OFS_ISR:    reg_rdata = 32'(isr_q);
      default:    reg_rdata = '0;
    endcase
  end

  assign ring_base = base_q;
  assign rx_en     = en_q;
  assign max_len   = maxlen_q;

  assert_missed_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_miss && !drop_evt) |=> (missed_q == '0));
  assert_missed_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && !wr_miss && missed_q != '1) |=> (missed_q == $past(missed_q) + 1'b1));
  assert_isr_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_isr && reg_wdata[ISR_OK] && !ok_evt) |=> !isr_q[ISR_OK]);
  assert_isr_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> isr_q[ISR_NOBUF]);

endmodule

// File: rtl/rxdesc_wb_pack.sv
module rxdesc_wb_pack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        take,
  input  logic [7:0]  data,
  input  logic        flush,
  input  logic        ack,
  output logic        pend,
  output logic [31:0] word
);

  logic [1:0]  lane_q, lane_b;
  logic [31:0] acc_q, acc_b, acc_n;
  logic        pend_q, emit;
  logic [31:0] word_q;

  always_comb begin
    lane_b = start ? 2'd0 : lane_q;
    acc_b  = start ? 32'h0 : acc_q;
    acc_n  = acc_b;
    if (take) acc_n[{lane_b, 3'b000} +: 8] = data;
    emit = (take && lane_b == 2'd3) || (flush && (take || lane_b != 2'd0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
      acc_q  <= '0;
      pend_q <= 1'b0;
      word_q <= '0;
    end else begin
      if (start || ack) pend_q <= 1'b0;
      if (emit) begin
        word_q <= acc_n;
        pend_q <= 1'b1;
        lane_q <= '0;
        acc_q  <= '0;
      end else begin
        lane_q <= lane_b + 2'(take);
        acc_q  <= acc_n;
      end
    end
  end

  assign pend = pend_q;
  assign word = word_q;

  assert_no_overwrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> (!pend_q || ack || start));

endmodule

// File: rtl/rxdesc_wb.sv
module rxdesc_wb
  import rxdesc_wb_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int MISS_W    = 16,
  parameter int MIN_FRAME = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  input  logic        rx_err
);

  localparam int CNT_W = LEN_W + 1;
  localparam int PAD_W = 32 - IDX_W - 4;

  rx_state_t        state_q, state_n;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             own_q, eor_q, crc_q, done_q;
  logic [LEN_W-1:0] lim_q;
  logic [31:0]      wptr_q;

  logic [31:0]      ring_base;
  logic             rx_en;
  logic [LEN_W-1:0] max_len;

  // Named internal events
  logic start_evt, byte_acc, last_acc, take, drop_evt, wb_evt, ok_evt, err_evt;
  logic pk_pend, pk_ack, overlong, runt, done_now;
  logic [31:0] pk_word, desc_addr, status_word;
  logic [LEN_W-1:0] wb_len;

  assign desc_addr = ring_base + {{PAD_W{1'b0}}, idx_q, 4'h0};
  assign start_evt = (state_q == ST_IDLE) && rx_valid && rx_en;
  assign byte_acc  = start_evt || (rx_valid && (state_q == ST_STAT ||
                     state_q == ST_ADDR || state_q == ST_RECV));
  assign last_acc  = byte_acc && rx_last;
  assign done_now  = done_q || last_acc;
  assign drop_evt  = (state_q == ST_ADDR) && !own_q;
  assign wb_evt    = (state_q == ST_WBACK);

  always_comb begin
    case (state_q)
      ST_IDLE, ST_STAT: take = byte_acc;
      ST_ADDR:          take = byte_acc && own_q && (cnt_q < {1'b0, lim_q});
      ST_RECV:          take = byte_acc && (cnt_q < {1'b0, lim_q});
      default:          take = 1'b0;
    endcase
  end

  assign overlong    = cnt_q > {1'b0, lim_q};
  assign runt        = cnt_q < CNT_W'(MIN_FRAME);
  assign wb_len      = overlong ? lim_q : cnt_q[LEN_W-1:0];
  assign status_word = wb_status(eor_q, crc_q, runt, overlong, wb_len);
  assign ok_evt      = wb_evt && !status_word[SUM_BIT];
  assign err_evt     = wb_evt && status_word[SUM_BIT];
  assign pk_ack      = pk_pend && (state_q == ST_RECV || state_q == ST_FLUSH);

  rxdesc_wb_regs #(.MISS_W(MISS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .drop_evt(drop_evt),
    .ok_evt(ok_evt), .err_evt(err_evt), .ring_base(ring_base),
    .rx_en(rx_en), .max_len(max_len)
  );

  rxdesc_wb_pack u_pack (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .take(take), .data(rx_data),
    .flush(last_acc), .ack(pk_ack), .pend(pk_pend), .word(pk_word)
  );

  // Memory port: descriptor reads at frame start, data words, status writeback.
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_addr;
    mem_wdata = '0;
    if (start_evt) begin
      mem_req = 1'b1;
    end else if (state_q == ST_STAT) begin
      mem_req  = 1'b1;
      mem_addr = desc_addr + 32'd8;
    end else if (pk_ack) begin
      mem_req   = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = wptr_q;
      mem_wdata = pk_word;
    end else if (wb_evt) begin
      mem_req   = 1'b1;
      mem_we    = 1'b1;
      mem_wdata = status_word;
    end
  end

  always_comb begin
    state_n = state_q;
    case (state_q)
      ST_IDLE:  if (start_evt) state_n = ST_STAT;
                else if (rx_valid && !rx_last) state_n = ST_SKIP;
      ST_STAT:  state_n = ST_ADDR;
      ST_ADDR:  if (!own_q) state_n = done_now ? ST_IDLE : ST_SKIP;
                else        state_n = done_now ? ST_FLUSH : ST_RECV;
      ST_RECV:  if (last_acc) state_n = ST_FLUSH;
      ST_FLUSH: state_n = ST_WBACK;
      ST_WBACK: state_n = ST_IDLE;
      ST_SKIP:  if (rx_valid && rx_last) state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      own_q   <= 1'b0;
      eor_q   <= 1'b0;
      crc_q   <= 1'b0;
      done_q  <= 1'b0;
      lim_q   <= '0;
      wptr_q  <= '0;
    end else begin
      state_q <= state_n;
      if (start_evt) begin
        cnt_q  <= CNT_W'(1);
        crc_q  <= rx_err;
        done_q <= rx_last;
      end else if (byte_acc) begin
        if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
        crc_q  <= crc_q | rx_err;
        done_q <= done_q | rx_last;
      end
      if (state_q == ST_STAT) begin
        own_q <= mem_rdata[OWN_BIT];
        eor_q <= mem_rdata[EOR_BIT];
        lim_q <= len_min(mem_rdata[LEN_W-1:0], max_len);
      end
      if (state_q == ST_ADDR) wptr_q <= mem_rdata;
      else if (pk_ack)        wptr_q <= wptr_q + 32'd4;
      if (wb_evt) idx_q <= eor_q ? '0 : idx_q + 1'b1;
    end
  end

  assert_own_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && wb_evt) |-> (!mem_wdata[OWN_BIT] && mem_addr == desc_addr));
  assert_len_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_evt |-> (mem_wdata[LEN_W-1:0] <= lim_q));
  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_evt && eor_q) |=> (idx_q == '0));
  assert_drop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) |-> !mem_req);
  assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !rx_en) |-> !mem_req);

endmodule

// File: tb/rxdesc_wb_bench.sv
module rxdesc_wb_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] len;
    logic        err;
    logic [12:0] bsz;
    logic [31:0] st;
    logic [15:0] nst;
  } vec_t;

  // frame length, error flag, buffer size, expected status, expected stored bytes
  localparam vec_t VECS [0:5] = '{
    '{16'd64,  1'b0, 13'd1536, 32'h0000_0040, 16'd64},   // clean, R3
    '{16'd100, 1'b1, 13'd1536, 32'h0028_0064, 16'd100},  // error flag, R6
    '{16'd10,  1'b0, 13'd1536, 32'h0030_000A, 16'd10},   // runt, R5
    '{16'd80,  1'b0, 13'd72,   32'h4060_0048, 16'd72},   // truncated, last desc, R4
    '{16'd67,  1'b0, 13'd1536, 32'h0000_0043, 16'd67},   // wrapped to desc 0, R7
    '{16'd70,  1'b1, 13'd40,   32'h0068_0028, 16'd40}    // truncated with error
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0;
  logic [7:0] rx_data = '0;

  logic [31:0] mem [0:1023];
  int req_cnt = 0;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_req) begin
      req_cnt <= req_cnt + 1;
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[11:2]];
    end
  end

  rxdesc_wb u_rxdesc_wb (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_err(rx_err)
  );

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'((seed * 16 + k * 3 + 1) & 255);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // side: 0 none, 1 clear missed counter with byte 2, 2 clear ISR bit 4 with byte 2
  task automatic send_frame(input int len, input bit err, input int seed, input int side);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      reg_wr = 1'b0;
      rx_valid = 1'b1; rx_data = pat(seed, k);
      rx_last = (k == len - 1); rx_err = err && (k == len - 1);
      if (k == 2 && side == 1) begin reg_wr = 1'b1; reg_addr = 8'h0C; reg_wdata = 32'h0; end
      if (k == 2 && side == 2) begin reg_wr = 1'b1; reg_addr = 8'h10; reg_wdata = 32'h10; end
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0; reg_wr = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  function automatic int dword(input int idx);   // descriptor status word index
    return 32'h40 + idx * 4;
  endfunction
  function automatic int bword(input int idx);   // buffer start word index
    return 256 + idx * 64;
  endfunction

  task automatic arm(input int idx, input logic [31:0] st);
    mem[dword(idx)]     = st;
    mem[dword(idx) + 1] = 32'h0;
    mem[dword(idx) + 2] = 32'(bword(idx) * 4);
    mem[dword(idx) + 3] = 32'h0;
    for (int w = 0; w < 64; w++) mem[bword(idx) + w] = 32'hA5A5_A5A5;
  endtask

  task automatic chk_data(input string tag, input int idx, input int seed, input int nst);
    int bad;
    int nw;
    logic [7:0] b;
    bad = 0;
    nw = (nst + 3) / 4;
    for (int k = 0; k < nw * 4; k++) begin
      b = mem[bword(idx) + k / 4][(k % 4) * 8 +: 8];
      if (k < nst && b !== pat(seed, k)) bad++;
      if (k >= nst && b !== 8'h00) bad++;
    end
    if (mem[bword(idx) + nw] !== 32'hA5A5_A5A5) bad++;
    chk(tag, 32'(bad), 32'h0);
  endtask

  initial begin
    logic [31:0] d;
    int cnt0;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(8'h00, d); chk("R1 base", d, 0);
    rd(8'h04, d); chk("R1 ctrl", d, 0);
    rd(8'h08, d); chk("R1 maxlen", d, 0);
    rd(8'h0C, d); chk("R1 missed", d, 0);
    rd(8'h10, d); chk("R1 isr", d, 0);
    chk("R1 no mem request", 32'(req_cnt), 0);

    // R11: base alignment
    wr(8'h00, 32'h0000_0123); rd(8'h00, d); chk("R11 base low bits", d, 32'h100);
    wr(8'h08, 32'd1536);

    // R2: disabled reception
    arm(0, 32'h8000_0600);
    cnt0 = req_cnt;
    send_frame(64, 1'b0, 9, 0);
    chk("R2 no access when disabled", 32'(req_cnt - cnt0), 0);
    rd(8'h0C, d); chk("R2 missed untouched", d, 0);
    rd(8'h10, d); chk("R2 isr untouched", d, 0);
    chk("R2 descriptor untouched", mem[dword(0)], 32'h8000_0600);
    wr(8'h04, 32'h08);

    // Vector table: R3 R4 R5 R6 R7 R9
    for (int e = 0; e < 6; e++) begin
      int di;
      di = e % 4;
      arm(di, 32'h8000_0000 | (di == 3 ? 32'h4000_0000 : 32'h0) | 32'(VECS[e].bsz));
      send_frame(int'(VECS[e].len), VECS[e].err, e, 0);
      chk($sformatf("R3/R4/R5/R6/R7 status vec %0d", e), mem[dword(di)], VECS[e].st);
      chk_data($sformatf("R3 data vec %0d", e), di, e, int'(VECS[e].nst));
      rd(8'h10, d);
      chk($sformatf("R9 isr vec %0d", e), d, VECS[e].st[21] ? 32'h2 : 32'h1);
      wr(8'h10, 32'h13);
    end
    rd(8'h10, d); chk("R9 w1c all", d, 0);

    // R4: maximum length register limits storage (descriptor 2 is next)
    wr(8'h08, 32'd50);
    arm(2, 32'h8000_0600);
    send_frame(70, 1'b0, 7, 0);
    chk("R4 maxlen status", mem[dword(2)], 32'h0060_0032);
    chk_data("R4 maxlen data", 2, 7, 50);
    wr(8'h08, 32'd1536);
    wr(8'h10, 32'h13);

    // R8: descriptor 3 not owned
    arm(3, 32'h4000_0600);
    cnt0 = req_cnt;
    send_frame(64, 1'b0, 3, 0);
    rd(8'h0C, d); chk("R8 missed count", d, 1);
    rd(8'h10, d); chk("R8 isr nobuf", d, 32'h10);
    chk("R8 descriptor untouched", mem[dword(3)], 32'h4000_0600);
    chk("R8 buffer untouched", mem[bword(3)], 32'hA5A5_A5A5);
    chk("R8 only two reads", 32'(req_cnt - cnt0), 2);

    // R10: clear in the same cycle as a drop
    send_frame(64, 1'b0, 3, 1);
    rd(8'h0C, d); chk("R10 clear with drop", d, 1);
    // R9: W1C of bit 4 in the same cycle as a drop
    send_frame(64, 1'b0, 3, 2);
    rd(8'h10, d); chk("R9 set wins", d, 32'h10);
    rd(8'h0C, d); chk("R8 missed second", d, 2);
    wr(8'h10, 32'h10); rd(8'h10, d); chk("R9 w1c bit4", d, 0);
    wr(8'h0C, 32'h0); rd(8'h0C, d); chk("R10 write clears", d, 0);

    // R8: index unchanged after drops, R7 wrap afterwards
    arm(3, 32'hC000_0600);
    send_frame(64, 1'b0, 5, 0);
    chk("R8 same descriptor used", mem[dword(3)], 32'h4000_0040);
    chk_data("R8 data after rearm", 3, 5, 64);
    arm(0, 32'h8000_0600);
    send_frame(65, 1'b0, 6, 0);
    chk("R7 wrap to descriptor 0", mem[dword(0)], 32'h0000_0041);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule